// File: doc/BRIEF.md
# Guarded Vertex Constant Store

This block is the constant memory of a vertex-processing unit. One RAM holds both the fixed-function transform parameters and the user-visible shader constants. Every shader read passes through an access check before any data leaves the block. The check looks at three things: the computed address, the kind of read, and a mode input that selects either unrestricted access or user-region-only access. A read that the check refuses returns an all-zero word rather than the stored entry.

There are two kinds of shader read. An absolute read takes its address straight from the instruction. An indexed read adds a signed index register to an encoded base. A shader can express a negative offset by encoding a base below the user region. Such a read then lands in the fixed-function area and, when the mode restricts access, reads as zero. A separate host write port loads any entry with no check at all. A compile-time generation parameter chooses where the regions lie and which kinds of read the mode restricts.

Top module: `vcg_top`

## Requirements
- R1: Read latency is one cycle. `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high. `rd_data` is all-zero in every cycle where `rd_valid` is low.
- R2: While `rst_n` is low, `rd_valid` and `rd_data` are zero.
- R3: With GEN = GEN_FIRST (value 0) and `user_only` = 1, an indexed read returns the stored entry only when its address lies in 0x60..0xBF. Any other indexed address returns zero.
- R4: With GEN = GEN_FIRST and `user_only` = 1, an absolute read returns the stored entry only at 0x3A, at 0x3B, or in 0x60..0xBF. Any other absolute address returns zero.
- R5: With `user_only` = 0, both kinds of read return the stored entry at every address from 0 to DEPTH-1, in both generations.
- R6: With GEN = GEN_SECOND (value 1), absolute reads are never restricted. With `user_only` = 1, an indexed read returns the stored entry only when its address lies in 0x9C..0x19B.
- R7: A computed address that is negative, or that is at or above DEPTH (default 0x1D4 = 468), returns zero in every mode and generation.
- R8: An indexed read uses address = `rd_base` + `rd_index`, where `rd_index` is a 10-bit two's-complement value. An absolute read (`rd_indexed` = 0) uses `rd_base` and ignores `rd_index`.
- R9: A host write stores `wr_data` at `wr_addr` in every mode. If a shader read targets the same entry in the same cycle, the read returns the old contents, and later reads return the new contents.
- R10: An entry is 128 bits wide, made of four 32-bit lanes. The entry is returned bit for bit as it was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 9 | Host write entry |
| wr_data | input | 128 | Host write word |
| rd_en | input | 1 | Shader read request |
| rd_indexed | input | 1 | 1 = indexed read, 0 = absolute read |
| rd_base | input | 9 | Address encoded in the instruction |
| rd_index | input | 10 | Signed index register value |
| user_only | input | 1 | 1 = user-region-only access, 0 = all addresses |
| rd_valid | output | 1 | Read result strobe, one cycle after `rd_en` |
| rd_data | output | 128 | Read result, zero when refused or idle |

## Verification
The bench targets the edges of each region: 0x39 through 0x3C, 0x5F/0x60, 0xBF/0xC0, 0x9B/0x9C and 0x19B/0x19C. A guard with an off-by-one error would leak a fixed-function word or blank a user constant at one of these points. It also drives indexed reads whose sum goes to -1, to exactly 468, or past 511. A design that drops the sign or the carry would wrap these around to a live entry instead of returning zero. The bench compares an absolute read of 0x3A under user-only mode in both generations, and an indexed read of a negative offset, to catch a design that applies the mode to the wrong kind of read. A write to an entry that is read in the same cycle is checked for the old word, which catches a RAM that forwards the new data.

// File: rtl/vcg_pkg.sv
`timescale 1ns/1ps
package vcg_pkg;

    // Selects the region layout and the way the mode restricts reads
    typedef enum logic [0:0] {
        GEN_FIRST  = 1'b0,
        GEN_SECOND = 1'b1
    } vcg_gen_e;

    // Fixed-function slots that stay readable by absolute reads
    localparam int unsigned VP_SCALE_SLOT = 32'h3A;
    localparam int unsigned VP_SHIFT_SLOT = 32'h3B;

    function automatic int unsigned user_lo(vcg_gen_e g);
        return (g == GEN_FIRST) ? 32'h60 : 32'h9C;
    endfunction

    function automatic int unsigned user_hi(vcg_gen_e g);
        return (g == GEN_FIRST) ? 32'hBF : 32'h19B;
    endfunction

    // State registered at the read output
    typedef struct packed {
        logic         valid;
        logic [127:0] data;
    } vcg_out_t;

endpackage

// File: rtl/vcg_addr_gen.sv
`timescale 1ns/1ps
module vcg_addr_gen #(
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 10,
    parameter int DEPTH  = 468
) (
    input  logic                    indexed,
    input  logic [ADDR_W-1:0]       base,
    input  logic signed [IDX_W-1:0] index,
    output logic [ADDR_W-1:0]       addr,
    output logic                    in_range
);
    // Two spare bits: one for the sign, one for the carry of the sum
    localparam int SUM_W = ((ADDR_W > IDX_W) ? ADDR_W : IDX_W) + 2;

    logic signed [SUM_W-1:0] base_s;
    logic signed [SUM_W-1:0] idx_s;
    logic signed [SUM_W-1:0] sum_s;
    logic signed [SUM_W-1:0] limit_s;

    always_comb begin
        base_s  = {{(SUM_W-ADDR_W){1'b0}}, base};
        idx_s   = indexed ? {{(SUM_W-IDX_W){index[IDX_W-1]}}, index} : '0;
        sum_s   = base_s + idx_s;
        limit_s = SUM_W'(DEPTH);
        in_range = !sum_s[SUM_W-1] && (sum_s < limit_s);
        addr     = sum_s[ADDR_W-1:0];
    end
endmodule

// File: rtl/vcg_guard.sv
`timescale 1ns/1ps
module vcg_guard #(
    parameter vcg_pkg::vcg_gen_e GEN = vcg_pkg::GEN_FIRST,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_range,
    input  logic              indexed,
    input  logic              user_only,
    output logic              allow
);
    localparam logic [ADDR_W-1:0] U_LO = ADDR_W'(vcg_pkg::user_lo(GEN));
    localparam logic [ADDR_W-1:0] U_HI = ADDR_W'(vcg_pkg::user_hi(GEN));
    localparam logic [ADDR_W-1:0] VP_A = ADDR_W'(vcg_pkg::VP_SCALE_SLOT);
    localparam logic [ADDR_W-1:0] VP_B = ADDR_W'(vcg_pkg::VP_SHIFT_SLOT);

    logic in_user;
    assign in_user = (addr >= U_LO) && (addr <= U_HI);

    generate
        if (GEN == vcg_pkg::GEN_FIRST) begin : g_first
            // Mode restricts both kinds; absolute keeps the two viewport slots
            logic vp_slot;
            assign vp_slot = (addr == VP_A) || (addr == VP_B);
            assign allow = in_range &&
                           (!user_only || in_user || (!indexed && vp_slot));
        end else begin : g_second
            // Mode restricts only indexed reads
            assign allow = in_range && (!user_only || !indexed || in_user);
        end
    endgenerate
endmodule

// File: rtl/vcg_store.sv
`timescale 1ns/1ps
module vcg_store #(
    parameter int DEPTH  = 468,
    parameter int WORD_W = 128,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              wr_ok;
    logic              rd_ok;

    assign wr_ok = wr_en && ({1'b0, wr_addr} < LIMIT);
    assign rd_ok = {1'b0, rd_addr} < LIMIT;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read; the caller registers it, so same-edge writes are not seen
    assign rd_word = rd_ok ? mem[rd_addr] : '0;
endmodule

// File: rtl/vcg_top.sv
`timescale 1ns/1ps
module vcg_top #(
    parameter vcg_pkg::vcg_gen_e GEN = vcg_pkg::GEN_FIRST,
    parameter int DEPTH  = 468,
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    parameter int IDX_W  = 10,
    localparam int WORD_W = LANE_W * LANES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic                    rd_indexed,
    input  logic [ADDR_W-1:0]       rd_base,
    input  logic signed [IDX_W-1:0] rd_index,
    input  logic                    user_only,
    output logic                    rd_valid,
    output logic [WORD_W-1:0]       rd_data
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } out_t;

    logic [ADDR_W-1:0] eff_addr;
    logic              eff_in_range;
    logic              allow;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_word;
    out_t              out_d;
    out_t              out_q;

    vcg_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) addr_i (
        .indexed  (rd_indexed),
        .base     (rd_base),
        .index    (rd_index),
        .addr     (eff_addr),
        .in_range (eff_in_range)
    );

    vcg_guard #(.GEN(GEN), .ADDR_W(ADDR_W)) guard_i (
        .addr      (eff_addr),
        .in_range  (eff_in_range),
        .indexed   (rd_indexed),
        .user_only (user_only),
        .allow     (allow)
    );

    assign ram_addr = allow ? eff_addr : '0;

    vcg_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ram_addr),
        .rd_word (ram_word)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = rd_en;
        out_d.data  = (rd_en && allow) ? ram_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_valid = out_q.valid;
    assign rd_data  = out_q.data;
endmodule

// File: rtl/vcg_checker.sv
`timescale 1ns/1ps
module vcg_checker #(
    parameter vcg_pkg::vcg_gen_e GEN = vcg_pkg::GEN_FIRST,
    parameter int DEPTH  = 468,
    parameter int WORD_W = 128,
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_en,
    input logic                    rd_indexed,
    input logic [ADDR_W-1:0]       rd_base,
    input logic signed [IDX_W-1:0] rd_index,
    input logic                    user_only,
    input logic                    rd_valid,
    input logic [WORD_W-1:0]       rd_data
);
    localparam int CW = ((ADDR_W > IDX_W) ? ADDR_W : IDX_W) + 2;
    localparam logic signed [CW-1:0] C_DEPTH = CW'(DEPTH);
    localparam logic signed [CW-1:0] C_ULO   = CW'(vcg_pkg::user_lo(GEN));
    localparam logic signed [CW-1:0] C_VPA   = CW'(vcg_pkg::VP_SCALE_SLOT);

    logic signed [CW-1:0] c_base;
    logic signed [CW-1:0] c_idx;
    logic signed [CW-1:0] c_sum;
    logic                 c_ok;

    assign c_base = {{(CW-ADDR_W){1'b0}}, rd_base};
    assign c_idx  = rd_indexed ? {{(CW-IDX_W){rd_index[IDX_W-1]}}, rd_index} : '0;
    assign c_sum  = c_base + c_idx;
    assign c_ok   = (c_sum >= 0) && (c_sum < C_DEPTH);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R1
    AST_QUIET_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R1
    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !c_ok) |=> (rd_data == '0)); // R7
    AST_IDX_BELOW_USER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_indexed && user_only && c_sum < C_ULO) |=> (rd_data == '0)); // R3
    AST_ABS_LOW_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (GEN == vcg_pkg::GEN_FIRST && rd_en && !rd_indexed && user_only && c_sum < C_VPA)
        |=> (rd_data == '0)); // R4
endmodule

bind vcg_top vcg_checker #(
    .GEN(GEN), .DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_indexed (rd_indexed),
    .rd_base    (rd_base),
    .rd_index   (rd_index),
    .user_only  (user_only),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/vcg_top_tb_top.sv
`timescale 1ns/1ps
module vcg_top_tb_top;
    localparam int DEPTH = 468;

    typedef struct {
        bit           v;
        logic [127:0] d;
        string        tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [8:0]         wr_addr;
    logic [127:0]       wr_data;
    logic               rd_en;
    logic               rd_indexed;
    logic [8:0]         rd_base;
    logic signed [9:0]  rd_index;
    logic               user_only;
    logic               v0, v1;
    logic [127:0]       d0, d1;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [127:0] ref_mem [DEPTH];
    exp_t q0[$];
    exp_t q1[$];

    always #2 clk = ~clk;

    vcg_top #(.GEN(vcg_pkg::GEN_FIRST)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_indexed(rd_indexed), .rd_base(rd_base), .rd_index(rd_index),
        .user_only(user_only), .rd_valid(v0), .rd_data(d0)
    );

    vcg_top #(.GEN(vcg_pkg::GEN_SECOND)) dut1_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_indexed(rd_indexed), .rd_base(rd_base), .rd_index(rd_index),
        .user_only(user_only), .rd_valid(v1), .rd_data(d1)
    );

    // R10: four distinct 32-bit lanes per entry
    function automatic logic [127:0] pat(int a, int salt);
        logic [31:0] x = 32'(a) ^ (32'(salt) << 20);
        return {x ^ 32'hA5A5_0000, x ^ 32'h5A5A_0000, ~x, x ^ 32'h0F0F_F000};
    endfunction

    // Behavioural expectation from the requirements
    function automatic exp_t expect_read(int gen);
        exp_t e;
        int   a;
        int   lo, hi;
        bit   ok;
        e.v = 1'b1;
        a   = rd_indexed ? int'(rd_base) + int'(rd_index) : int'(rd_base);
        lo  = (gen == 0) ? 'h60 : 'h9C;
        hi  = (gen == 0) ? 'hBF : 'h19B;
        if (a < 0 || a >= DEPTH) begin
            e.d = '0; e.tag = "R7"; return e;
        end
        if (!user_only)              ok = 1;
        else if (a >= lo && a <= hi) ok = 1;
        else if (gen == 1)           ok = !rd_indexed;
        else                         ok = !rd_indexed && (a == 'h3A || a == 'h3B);
        e.d = ok ? ref_mem[a] : '0;
        if (wr_en && int'(wr_addr) == a)              e.tag = "R9";
        else if (rd_indexed && rd_index != 0 && !user_only) e.tag = "R8";
        else if (!user_only)                           e.tag = "R5";
        else if (gen == 1)                             e.tag = "R6";
        else if (rd_indexed)                           e.tag = "R3";
        else                                           e.tag = "R4";
        return e;
    endfunction

    always @(posedge clk) begin
        exp_t e0, e1;
        if (!rst_n) begin
            e0.v = 0; e0.d = '0; e0.tag = "R2"; e1 = e0;
        end else if (!rd_en) begin
            e0.v = 0; e0.d = '0; e0.tag = "R1"; e1 = e0;
        end else begin
            e0 = expect_read(0);
            e1 = expect_read(1);
        end
        q0.push_back(e0);
        q1.push_back(e1);
        if (rst_n && wr_en && int'(wr_addr) < DEPTH) ref_mem[wr_addr] = wr_data;
    end

    task automatic check_one(string inst, logic av, logic [127:0] ad, exp_t e);
        total++;
        if (av !== e.v || ad !== e.d) begin
            bad++;
            $display("FAIL %s %s: got v=%0b d=%h expected v=%0b d=%h",
                     e.tag, inst, av, ad, e.v, e.d);
        end
    endtask

    always @(negedge clk) begin
        if (q0.size() > 0) check_one("gen0", v0, d0, q0.pop_front());
        if (q1.size() > 0) check_one("gen1", v1, d1, q1.pop_front());
    end

    task automatic step(bit we, int wa, logic [127:0] wd,
                        bit re, bit ind, int base, int idx, bit uo);
        @(posedge clk);
        #1;
        wr_en = we; wr_addr = 9'(wa); wr_data = wd;
        rd_en = re; rd_indexed = ind; rd_base = 9'(base); rd_index = 10'(idx);
        user_only = uo;
    endtask

    task automatic rd(bit ind, int base, int idx, bit uo);
        step(0, 0, '0, 1, ind, base, idx, uo);
    endtask

    initial begin
        int pts[] = '{'h000, 'h039, 'h03A, 'h03B, 'h03C, 'h05F, 'h060, 'h0BF, 'h0C0,
                      'h09B, 'h09C, 'h19B, 'h19C, 'h1D3, 'h1D4, 'h1FF};
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 0;
        rd_indexed = 0; rd_base = 0; rd_index = 0; user_only = 0;
        repeat (3) @(posedge clk);   // R2 checked while in reset
        #1 rst_n = 1;

        for (int a = 0; a < DEPTH; a++) step(1, a, pat(a, 1), 0, 0, 0, 0, 0);

        for (int uo = 0; uo < 2; uo++) begin
            foreach (pts[i]) begin
                rd(0, pts[i], 0, uo[0]);            // R3 R4 R5 R6 absolute
                rd(0, pts[i], -7, uo[0]);           // R8 index ignored when absolute
                rd(1, pts[i], 0, uo[0]);            // indexed, zero offset
                if (pts[i] + 5 < 512) rd(1, pts[i] + 5, -5, uo[0]);
            end
            rd(1, 'h060, -'h20, uo[0]);  // R8 negative offset into fixed area
            rd(1, 'h010, -'h11, uo[0]);  // R7 sum -1
            rd(1, 'h1D0, 4, uo[0]);      // R7 sum 468
            rd(1, 'h1FF, -512, uo[0]);   // R7 sum -1 from top base
            rd(1, 'h000, 511, uo[0]);    // R7 sum 511
            rd(1, 'h100, 'h9B, uo[0]);   // sum 0x19B
        end

        // R9: same-cycle write and read return the old entry, later read the new one
        step(1, 'h70, pat('h70, 2), 1, 0, 'h70, 0, 0);
        rd(0, 'h70, 0, 0);
        step(1, 'h20, pat('h20, 3), 1, 1, 'h20, 0, 1);
        rd(0, 'h20, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            bit we = ($urandom % 4) == 0;
            int wa = $urandom % DEPTH;
            int base = (($urandom % 2) == 0) ? 'h30 + ($urandom % 'h180) : $urandom % 512;
            int idx  = int'($signed(10'($urandom)));
            if (($urandom % 3) == 0) idx = idx % 16;
            step(we, wa, pat(wa, 4 + n), ($urandom % 5) != 0, $urandom % 2, base, idx,
                 $urandom % 2);
        end

        step(0, 0, '0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog: got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule